// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps, for every architectural register, a busy flag and the reorder buffer entry number that will produce the newest value of that register. When an instruction issues, the block resolves both of its source registers in the same cycle. There are three outcomes. If no producer is pending, the operand comes from the committed register file. If the producer has finished but not retired, the operand is its value in the reorder buffer. If the producer is still running, the block returns that producer's entry number as a tag to wait on. A result broadcast in the same cycle as the lookup is forwarded directly. When the instruction writes a register, the block records the instruction's own entry number as the new producer.

At retirement the mapping for the retiring destination is released, but only if it still names the retiring entry. A flush drops every pending mapping, which undoes the renames made by squashed instructions. The register file and the reorder buffer storage lie outside the block. The block drives their read addresses and takes back the data, the ready flags and the values.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register is unmapped. Each lookup returns source code 0 (register file), the register file data read at the source register number, and tag 0.
- R2: An issue with `iss_valid=1` and `iss_dst_we=1` maps `iss_dst` to `iss_tag`. Lookups from the next cycle on report that tag for that register.
- R3: When a mapped register's producer entry is ready (the ready flag read at the tag address), the lookup returns source code 1 with that entry's value. The reorder buffer read address equals the stored tag.
- R4: When a mapped register's producer entry is not ready and no matching broadcast is present, the lookup returns source code 3, value 0 and the stored tag.
- R5: When the producer entry is not ready but `cdb_valid` is set and `cdb_tag` equals the stored tag, the lookup returns source code 2 with `cdb_value`.
- R6: A retirement (`ret_valid`) whose `ret_tag` equals the stored tag of `ret_dst` unmaps that register from the next cycle on.
- R7: A retirement whose tag differs from the stored tag of `ret_dst` leaves the younger mapping unchanged.
- R8: When a destination update and a matching retirement name the same register in one cycle, the update wins and the register is mapped to the new tag.
- R9: A lookup made in the same cycle as a destination update to the same register sees the mapping as it stood before that update.
- R10: `flush` unmaps every register from the next cycle on, and it takes priority over an issue or a retirement in the same cycle.
- R11: An issue with `iss_valid=0`, or with `iss_dst_we=0`, changes no mapping.
- R12: The two source lookups are independent. Each one uses only its own register number and its own register file and reorder buffer read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Drop all mappings |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst_we | input | 1 | The issuing instruction writes a register |
| iss_src_a | input | REG_W | First source register |
| iss_src_b | input | REG_W | Second source register |
| iss_dst | input | REG_W | Destination register |
| iss_tag | input | TAG_W | Reorder buffer entry of the issuing instruction |
| ret_valid | input | 1 | A register-writing entry retires |
| ret_dst | input | REG_W | Destination of the retiring entry |
| ret_tag | input | TAG_W | Entry number of the retiring entry |
| cdb_valid | input | 1 | A result broadcast is present |
| cdb_tag | input | TAG_W | Entry number of the broadcast result |
| cdb_value | input | DATA_W | Broadcast result value |
| rf_raddr_a | output | REG_W | Register file read address, source A |
| rf_raddr_b | output | REG_W | Register file read address, source B |
| rf_rdata_a | input | DATA_W | Register file data, source A |
| rf_rdata_b | input | DATA_W | Register file data, source B |
| rob_raddr_a | output | TAG_W | Reorder buffer read address, source A |
| rob_raddr_b | output | TAG_W | Reorder buffer read address, source B |
| rob_ready_a | input | 1 | Ready flag of entry at rob_raddr_a |
| rob_ready_b | input | 1 | Ready flag of entry at rob_raddr_b |
| rob_value_a | input | DATA_W | Value of entry at rob_raddr_a |
| rob_value_b | input | DATA_W | Value of entry at rob_raddr_b |
| opa_src | output | 2 | Source code A: 0 file, 1 buffer, 2 broadcast, 3 wait |
| opa_value | output | DATA_W | Operand A value (0 when waiting) |
| opa_tag | output | TAG_W | Producer tag of A (0 when unmapped) |
| opb_src | output | 2 | Source code B |
| opb_value | output | DATA_W | Operand B value |
| opb_tag | output | TAG_W | Producer tag of B |

## Verification
Operand resolution is combinational. The bench drives inputs after a falling edge and samples source code, value and tag one nanosecond later, before the next rising edge. Updates to the table, whether from issue, retirement or flush, take effect on the following rising edge. Each scenario therefore applies its update, lets one rising edge pass, and only then looks up the affected register. Same-cycle cases (R8, R9, the R10 priority) are driven together in one cycle and read back in the next.

// File: rtl/rst_pkg.sv
package rst_pkg;

  typedef enum logic [1:0] {
    SRC_RF   = 2'd0,
    SRC_ROB  = 2'd1,
    SRC_CDB  = 2'd2,
    SRC_WAIT = 2'd3
  } opnd_src_e;

  // Where an operand comes from, given the mapping and producer state.
  function automatic opnd_src_e pick_source(input logic mapped,
                                            input logic prod_ready,
                                            input logic bcast_hit);
    if (!mapped)         return SRC_RF;
    else if (prod_ready) return SRC_ROB;
    else if (bcast_hit)  return SRC_CDB;
    else                 return SRC_WAIT;
  endfunction

  // Next busy state of one register entry; flush > update > retire.
  function automatic logic next_busy(input logic cur, input logic flush_i,
                                     input logic upd, input logic ret_hit);
    if (flush_i)      return 1'b0;
    else if (upd)     return 1'b1;
    else if (ret_hit) return 1'b0;
    else              return cur;
  endfunction

endpackage

// File: rtl/rst_map_table.sv
module rst_map_table #(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5,
  parameter int TAG_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               upd_en,
  input  logic [REG_W-1:0]   upd_reg,
  input  logic [TAG_W-1:0]   upd_tag,
  input  logic               ret_en,
  input  logic [REG_W-1:0]   ret_reg,
  input  logic [TAG_W-1:0]   ret_tag,
  input  logic [REG_W-1:0]   rd_reg_a,
  input  logic [REG_W-1:0]   rd_reg_b,
  output logic               rd_busy_a,
  output logic [TAG_W-1:0]   rd_tag_a,
  output logic               rd_busy_b,
  output logic [TAG_W-1:0]   rd_tag_b,
  output logic [NUM_REGS-1:0] busy_vec
);
  import rst_pkg::*;

  localparam int TAGS_W = NUM_REGS * TAG_W;

  logic [TAGS_W-1:0] tag_flat;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    logic             busy_r;
    logic [TAG_W-1:0] tag_r;
    logic             upd_hit;
    logic             ret_hit;

    assign upd_hit = upd_en && (upd_reg == REG_W'(i));
    assign ret_hit = ret_en && (ret_reg == REG_W'(i)) && busy_r && (tag_r == ret_tag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_r <= 1'b0;
        tag_r  <= '0;
      end else begin
        busy_r <= next_busy(busy_r, flush, upd_hit, ret_hit);
        if (!flush && upd_hit) tag_r <= upd_tag;
      end
    end

    assign busy_vec[i] = busy_r;
    assign tag_flat[i*TAG_W +: TAG_W] = tag_r;
  end

  assign rd_busy_a = busy_vec[rd_reg_a];
  assign rd_busy_b = busy_vec[rd_reg_b];
  assign rd_tag_a  = tag_flat[rd_reg_a*TAG_W +: TAG_W];
  assign rd_tag_b  = tag_flat[rd_reg_b*TAG_W +: TAG_W];

endmodule

// File: rtl/rst_operand_resolve.sv
module rst_operand_resolve #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              map_busy,
  input  logic [TAG_W-1:0]  map_tag,
  input  logic [DATA_W-1:0] rf_data,
  input  logic              rob_ready,
  input  logic [DATA_W-1:0] rob_value,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  output logic [1:0]        src,
  output logic [DATA_W-1:0] value,
  output logic [TAG_W-1:0]  tag
);
  import rst_pkg::*;

  opnd_src_e sel;
  logic      bcast_hit;

  assign bcast_hit = cdb_valid && (cdb_tag == map_tag);
  assign sel       = pick_source(map_busy, rob_ready, bcast_hit);

  always_comb begin
    unique case (sel)
      SRC_RF:  value = rf_data;
      SRC_ROB: value = rob_value;
      SRC_CDB: value = cdb_value;
      default: value = '0;
    endcase
  end

  assign src = sel;
  assign tag = map_busy ? map_tag : '0;

endmodule

// File: rtl/rename_status_table.sv
module rename_status_table #(
  parameter int NUM_REGS = 32,
  parameter int ROB_DEPTH = 16,
  parameter int DATA_W = 32,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int TAG_W = $clog2(ROB_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              iss_valid,
  input  logic              iss_dst_we,
  input  logic [REG_W-1:0]  iss_src_a,
  input  logic [REG_W-1:0]  iss_src_b,
  input  logic [REG_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              ret_valid,
  input  logic [REG_W-1:0]  ret_dst,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  output logic [REG_W-1:0]  rf_raddr_a,
  output logic [REG_W-1:0]  rf_raddr_b,
  input  logic [DATA_W-1:0] rf_rdata_a,
  input  logic [DATA_W-1:0] rf_rdata_b,
  output logic [TAG_W-1:0]  rob_raddr_a,
  output logic [TAG_W-1:0]  rob_raddr_b,
  input  logic              rob_ready_a,
  input  logic              rob_ready_b,
  input  logic [DATA_W-1:0] rob_value_a,
  input  logic [DATA_W-1:0] rob_value_b,
  output logic [1:0]        opa_src,
  output logic [DATA_W-1:0] opa_value,
  output logic [TAG_W-1:0]  opa_tag,
  output logic [1:0]        opb_src,
  output logic [DATA_W-1:0] opb_value,
  output logic [TAG_W-1:0]  opb_tag
);

  localparam int NUM_SRC = 2;

  // Named internal events, also seen by the checker.
  logic                upd_en;
  logic [NUM_REGS-1:0] busy_vec;

  assign upd_en = iss_valid && iss_dst_we;

  logic             map_busy [NUM_SRC];
  logic [TAG_W-1:0] map_tag  [NUM_SRC];
  logic [DATA_W-1:0] rf_d    [NUM_SRC];
  logic              rob_r   [NUM_SRC];
  logic [DATA_W-1:0] rob_v   [NUM_SRC];
  logic [1:0]        res_src [NUM_SRC];
  logic [DATA_W-1:0] res_val [NUM_SRC];
  logic [TAG_W-1:0]  res_tag [NUM_SRC];

  rst_map_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .TAG_W(TAG_W)) map_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .upd_en   (upd_en),
    .upd_reg  (iss_dst),
    .upd_tag  (iss_tag),
    .ret_en   (ret_valid),
    .ret_reg  (ret_dst),
    .ret_tag  (ret_tag),
    .rd_reg_a (iss_src_a),
    .rd_reg_b (iss_src_b),
    .rd_busy_a(map_busy[0]),
    .rd_tag_a (map_tag[0]),
    .rd_busy_b(map_busy[1]),
    .rd_tag_b (map_tag[1]),
    .busy_vec (busy_vec)
  );

  assign rf_d[0]  = rf_rdata_a;
  assign rf_d[1]  = rf_rdata_b;
  assign rob_r[0] = rob_ready_a;
  assign rob_r[1] = rob_ready_b;
  assign rob_v[0] = rob_value_a;
  assign rob_v[1] = rob_value_b;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    rst_operand_resolve #(.DATA_W(DATA_W), .TAG_W(TAG_W)) res_i (
      .map_busy (map_busy[s]),
      .map_tag  (map_tag[s]),
      .rf_data  (rf_d[s]),
      .rob_ready(rob_r[s]),
      .rob_value(rob_v[s]),
      .cdb_valid(cdb_valid),
      .cdb_tag  (cdb_tag),
      .cdb_value(cdb_value),
      .src      (res_src[s]),
      .value    (res_val[s]),
      .tag      (res_tag[s])
    );
  end

  assign rf_raddr_a  = iss_src_a;
  assign rf_raddr_b  = iss_src_b;
  assign rob_raddr_a = map_tag[0];
  assign rob_raddr_b = map_tag[1];

  assign opa_src   = res_src[0];
  assign opa_value = res_val[0];
  assign opa_tag   = res_tag[0];
  assign opb_src   = res_src[1];
  assign opb_value = res_val[1];
  assign opb_tag   = res_tag[1];

endmodule

// File: rtl/rst_checker.sv
module rst_checker #(
  parameter int NUM_REGS = 32,
  parameter int REG_W = 5,
  parameter int TAG_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              iss_valid,
  input logic              iss_dst_we,
  input logic [REG_W-1:0]  iss_src_a,
  input logic [REG_W-1:0]  iss_dst,
  input logic [TAG_W-1:0]  iss_tag,
  input logic              ret_valid,
  input logic [REG_W-1:0]  ret_dst,
  input logic [TAG_W-1:0]  ret_tag,
  input logic              cdb_valid,
  input logic [TAG_W-1:0]  cdb_tag,
  input logic              rob_ready_a,
  input logic [TAG_W-1:0]  rob_raddr_a,
  input logic [1:0]        opa_src,
  input logic [TAG_W-1:0]  opa_tag,
  input logic [1:0]        opb_src,
  input logic              upd_en,
  input logic [NUM_REGS-1:0] busy_vec
);
  import rst_pkg::*;

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy_vec == '0) && (opa_src == SRC_RF) && (opb_src == SRC_RF));

  assert_rename_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !flush) |=>
      ((iss_src_a != $past(iss_dst)) || ((opa_src != SRC_RF) && (opa_tag == $past(iss_tag)))));

  assert_rob_ready_used_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (opa_src == SRC_ROB) |-> (rob_ready_a && (rob_raddr_a == opa_tag)));

  assert_wait_no_bcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opa_src == SRC_WAIT) |-> !(cdb_valid && (cdb_tag == opa_tag)));

  assert_retire_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !flush && !(upd_en && (iss_dst == ret_dst)) && busy_vec[ret_dst]
     && (iss_src_a == ret_dst) && (opa_tag == ret_tag))
    |=> !busy_vec[$past(ret_dst)]);

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> ($countones(busy_vec) <= $countones($past(busy_vec))));

endmodule

bind rename_status_table rst_checker #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/rename_status_table_tb.sv
module rename_status_table_tb_top;

  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5ns clk = ~clk;

  logic flush, iss_valid, iss_dst_we, ret_valid, cdb_valid;
  logic [4:0] iss_src_a, iss_src_b, iss_dst, ret_dst;
  logic [3:0] iss_tag, ret_tag, cdb_tag;
  logic [DW-1:0] cdb_value;
  logic [4:0] rf_raddr_a, rf_raddr_b;
  logic [DW-1:0] rf_rdata_a, rf_rdata_b;
  logic [3:0] rob_raddr_a, rob_raddr_b;
  logic rob_ready_a, rob_ready_b;
  logic [DW-1:0] rob_value_a, rob_value_b;
  logic [1:0] opa_src, opb_src;
  logic [DW-1:0] opa_value, opb_value;
  logic [3:0] opa_tag, opb_tag;

  logic          rob_rdy [16];
  logic [DW-1:0] rob_val [16];

  assign rf_rdata_a  = 32'hA000_0000 | 32'(rf_raddr_a);
  assign rf_rdata_b  = 32'hA000_0000 | 32'(rf_raddr_b);
  assign rob_ready_a = rob_rdy[rob_raddr_a];
  assign rob_ready_b = rob_rdy[rob_raddr_b];
  assign rob_value_a = rob_val[rob_raddr_a];
  assign rob_value_b = rob_val[rob_raddr_b];

  rename_status_table dut_i (.*);

  int errors = 0;
  int checks = 0;
  bit done = 0;

  function automatic logic [DW-1:0] rfv(input int r);
    return 32'hA000_0000 | r;
  endfunction

  task automatic expect_op(input string req, input bit side_b, input logic [1:0] s,
                           input logic [DW-1:0] v, input logic [3:0] t);
    logic [1:0] as; logic [DW-1:0] av; logic [3:0] at;
    as = side_b ? opb_src : opa_src;
    av = side_b ? opb_value : opa_value;
    at = side_b ? opb_tag : opa_tag;
    checks++;
    if (as !== s || av !== v || at !== t) begin
      errors++;
      $display("FAIL %s side %0d: got src=%0d val=%h tag=%0d, want src=%0d val=%h tag=%0d",
               req, side_b, as, av, at, s, v, t);
    end
  endtask

  task automatic idle();
    flush = 0; iss_valid = 0; iss_dst_we = 0; ret_valid = 0; cdb_valid = 0;
    iss_src_a = 0; iss_src_b = 0; iss_dst = 0; iss_tag = 0;
    ret_dst = 0; ret_tag = 0; cdb_tag = 0; cdb_value = 0;
  endtask

  task automatic edge_then_idle();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic do_issue(input int d, input int t);
    iss_valid = 1; iss_dst_we = 1; iss_dst = 5'(d); iss_tag = 4'(t);
    edge_then_idle();
  endtask

  task automatic t_reset();
    for (int r = 0; r < 32; r += 5) begin
      iss_src_a = 5'(r); iss_src_b = 5'(31 - r); #1ns;
      expect_op("R1", 0, 2'd0, rfv(r), 4'd0);
      expect_op("R1", 1, 2'd0, rfv(31 - r), 4'd0);
    end
    idle();
  endtask

  task automatic t_rename();
    iss_valid = 1; iss_dst_we = 1; iss_dst = 3; iss_tag = 5; iss_src_a = 3; #1ns;
    expect_op("R9", 0, 2'd0, rfv(3), 4'd0);
    edge_then_idle();
    iss_src_a = 3; iss_src_b = 4; #1ns;
    expect_op("R2/R4", 0, 2'd3, '0, 4'd5);
    expect_op("R12", 1, 2'd0, rfv(4), 4'd0);
  endtask

  task automatic t_rob();
    rob_rdy[5] = 1; rob_val[5] = 32'h0000_0055;
    iss_src_a = 3; iss_src_b = 3; #1ns;
    expect_op("R3", 0, 2'd1, 32'h55, 4'd5);
    expect_op("R3", 1, 2'd1, 32'h55, 4'd5);
    idle();
  endtask

  task automatic t_cdb();
    do_issue(7, 6);
    iss_src_b = 7; iss_src_a = 3; cdb_valid = 1; cdb_tag = 6; cdb_value = 32'h66; #1ns;
    expect_op("R5", 1, 2'd2, 32'h66, 4'd6);
    expect_op("R12", 0, 2'd1, 32'h55, 4'd5);
    cdb_tag = 9; #1ns;
    expect_op("R4", 1, 2'd3, '0, 4'd6);
    idle();
  endtask

  task automatic t_retire();
    ret_valid = 1; ret_dst = 3; ret_tag = 5;
    edge_then_idle();
    iss_src_a = 3; #1ns;
    expect_op("R6", 0, 2'd0, rfv(3), 4'd0);
    idle();
  endtask

  task automatic t_stale();
    do_issue(9, 1);
    do_issue(9, 2);
    ret_valid = 1; ret_dst = 9; ret_tag = 1;
    edge_then_idle();
    iss_src_a = 9; #1ns;
    expect_op("R7", 0, 2'd3, '0, 4'd2);
    idle();
  endtask

  task automatic t_same_cycle();
    do_issue(10, 3);
    iss_valid = 1; iss_dst_we = 1; iss_dst = 10; iss_tag = 4;
    ret_valid = 1; ret_dst = 10; ret_tag = 3;
    edge_then_idle();
    iss_src_b = 10; #1ns;
    expect_op("R8", 1, 2'd3, '0, 4'd4);
    idle();
  endtask

  task automatic t_no_write();
    iss_valid = 1; iss_dst_we = 0; iss_dst = 13; iss_tag = 7;
    edge_then_idle();
    iss_valid = 0; iss_dst_we = 1; iss_dst = 14; iss_tag = 7;
    edge_then_idle();
    iss_src_a = 13; iss_src_b = 14; #1ns;
    expect_op("R11", 0, 2'd0, rfv(13), 4'd0);
    expect_op("R11", 1, 2'd0, rfv(14), 4'd0);
    idle();
  endtask

  task automatic t_flush();
    iss_src_a = 7; #1ns;
    expect_op("R10 pre", 0, 2'd3, '0, 4'd6);
    flush = 1; iss_valid = 1; iss_dst_we = 1; iss_dst = 15; iss_tag = 8;
    ret_valid = 1; ret_dst = 9; ret_tag = 2;
    edge_then_idle();
    iss_src_a = 9; iss_src_b = 15; #1ns;
    expect_op("R10", 0, 2'd0, rfv(9), 4'd0);
    expect_op("R10", 1, 2'd0, rfv(15), 4'd0);
    iss_src_a = 7; iss_src_b = 10; #1ns;
    expect_op("R10", 0, 2'd0, rfv(7), 4'd0);
    expect_op("R10", 1, 2'd0, rfv(10), 4'd0);
    idle();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin rob_rdy[i] = 0; rob_val[i] = '0; end
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rename();
    t_rob();
    t_cdb();
    t_retire();
    t_stale();
    t_same_cycle();
    t_no_write();
    t_flush();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100us;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang, want completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule